// File: doc/BRIEF.md
# Configurable Output Macrocell

This block models a single output cell of a small programmable logic array. A bus of product terms arrives from an AND array outside the block. A mask of the same width chooses which terms take part, and the chosen terms are ORed into one sum bit. The sum feeds a D flip-flop. A two-bit mode word then picks the value on the pin from four paths: the stored bit or the live sum, each in true or inverted form.

A second output returns a signal to the AND array as feedback. In the two registered modes this is the flip-flop value, and in the two combinational modes it is the live sum. The feedback is always taken in true form, whatever pin polarity is chosen.

The mode word acts on the pin and the feedback straight away, without waiting for a clock edge. The flip-flop clears on a synchronous reset.

Top module: `olm_macrocell`

## Requirements
- R1: The sum is the OR of every product term whose mask bit is 1. An all-zero mask gives a sum of 0.
- R2: On each rising clock edge with reset low, the flip-flop loads the sum present at that edge.
- R3: A rising edge with reset high clears the flip-flop to 0. After it, the pin reads 0 in mode 2'b01 and 1 in mode 2'b00.
- R4: In mode 2'b00 the pin carries the inverse of the flip-flop.
- R5: In mode 2'b01 the pin carries the flip-flop value.
- R6: In mode 2'b10 the pin carries the inverse of the live sum.
- R7: In mode 2'b11 the pin carries the live sum.
- R8: The feedback equals the flip-flop value when mode bit 1 is 0, and the live sum when mode bit 1 is 1. It is never inverted.
- R9: A change of the mode word alters the pin and the feedback within the same cycle, with no clock edge between.
- R10: A product term whose mask bit is 0 has no effect on the sum, the flip-flop or the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flip-flop loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_mode | input | 2 | Output path select; bit 1 picks combinational, bit 0 picks true polarity |
| pterm | input | N_TERMS | Product terms from the AND array |
| pterm_en | input | N_TERMS | Term mask; 1 lets the matching term into the sum |
| pin_out | output | 1 | Pin value |
| fb_out | output | 1 | Feedback value returned to the AND array |

## Verification
The clocked properties assume that the mode word, the terms and the mask are settled at each rising edge and do not change at the edge itself. The bench changes every input only on the falling edge, so each sampled value is a stable one. The registered-path properties also assume that reset was low on the edge before the one they look at. They are disabled while reset is high, and the bench raises reset only now and then among its random cycles, so both the registered and the cleared cases are covered.

// File: rtl/olm_pkg.sv
package olm_pkg;

   typedef enum logic [1:0] {
      MODE_REG_LOW   = 2'b00,
      MODE_REG_HIGH  = 2'b01,
      MODE_COMB_LOW  = 2'b10,
      MODE_COMB_HIGH = 2'b11
   } olm_mode_e;

   localparam int unsigned OLM_MAX_TERMS = 64;

   function automatic logic is_comb_mode(input olm_mode_e m);
      return m[1];
   endfunction

   function automatic logic is_true_polarity(input olm_mode_e m);
      return m[0];
   endfunction

endpackage

// File: rtl/olm_term_sum.sv
module olm_term_sum #(
   parameter int unsigned N_TERMS  = 8,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [N_TERMS-1:0] terms,
   input  logic [N_TERMS-1:0] enables,
   output logic               sum
);
   localparam int unsigned LEVELS = (N_TERMS > 1) ? $clog2(N_TERMS) : 1;
   localparam int unsigned PADDED = 1 << LEVELS;

   logic [N_TERMS-1:0] gated;

   generate
      if (N_TERMS < 1 || N_TERMS > olm_pkg::OLM_MAX_TERMS) begin : g_bad_width
         $error("olm_term_sum: N_TERMS out of range");
      end

      for (genvar i = 0; i < N_TERMS; i++) begin : g_gate
         assign gated[i] = terms[i] & enables[i];
      end

      if (USE_TREE) begin : g_tree
         logic [2*PADDED-2:0] node;
         for (genvar k = 0; k < PADDED; k++) begin : g_leaf
            if (k < N_TERMS) begin : g_real
               assign node[PADDED-1+k] = gated[k];
            end else begin : g_pad
               assign node[PADDED-1+k] = 1'b0;
            end
         end
         for (genvar n = 0; n < PADDED-1; n++) begin : g_node
            assign node[n] = node[2*n+1] | node[2*n+2];
         end
         assign sum = node[0];
      end else begin : g_flat
         assign sum = |gated;
      end
   endgenerate

endmodule

// File: rtl/olm_state_reg.sv
module olm_state_reg (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d;
   end

   // R2: the register follows its data input one edge later
   property p_capture_r2;
      @(posedge clk) disable iff (rst) !rst |=> (q == $past(d));
   endproperty
   a_capture_r2: assert property (p_capture_r2);

   // R3: a reset edge leaves the register cleared
   property p_reset_clears_r3;
      @(posedge clk) rst |=> (q == 1'b0);
   endproperty
   a_reset_clears_r3: assert property (p_reset_clears_r3);

endmodule

// File: rtl/olm_path_mux.sv
module olm_path_mux
   import olm_pkg::*;
(
   input  olm_mode_e mode,
   input  logic      sum,
   input  logic      q,
   output logic      pin,
   output logic      fb
);
   logic [3:0] choice;

   assign choice[MODE_REG_LOW]   = ~q;
   assign choice[MODE_REG_HIGH]  =  q;
   assign choice[MODE_COMB_LOW]  = ~sum;
   assign choice[MODE_COMB_HIGH] =  sum;

   always_comb begin
      pin = choice[mode];
   end

   always_comb begin
      if (is_comb_mode(mode)) fb = sum;
      else                    fb = q;
   end

endmodule

// File: rtl/olm_macrocell.sv
module olm_macrocell
   import olm_pkg::*;
#(
   parameter int unsigned N_TERMS  = 8,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [1:0]         sel_mode,
   input  logic [N_TERMS-1:0] pterm,
   input  logic [N_TERMS-1:0] pterm_en,
   output logic               pin_out,
   output logic               fb_out
);
   olm_mode_e mode;
   logic      sum;
   logic      q;

   assign mode = olm_mode_e'(sel_mode);

   olm_term_sum #(.N_TERMS(N_TERMS), .USE_TREE(USE_TREE)) u_sum (
      .terms   (pterm),
      .enables (pterm_en),
      .sum     (sum)
   );

   olm_state_reg u_reg (
      .clk (clk),
      .rst (rst),
      .d   (sum),
      .q   (q)
   );

   olm_path_mux u_mux (
      .mode (mode),
      .sum  (sum),
      .q    (q),
      .pin  (pin_out),
      .fb   (fb_out)
   );

   // R7: true combinational mode shows the masked OR of the port terms
   property p_comb_true_r7;
      @(posedge clk) disable iff (rst)
         (sel_mode == 2'b11) |-> (pin_out == |(pterm & pterm_en));
   endproperty
   a_comb_true_r7: assert property (p_comb_true_r7);

   // R6: inverted combinational mode
   property p_comb_inv_r6;
      @(posedge clk) disable iff (rst)
         (sel_mode == 2'b10) |-> (pin_out == ~|(pterm & pterm_en));
   endproperty
   a_comb_inv_r6: assert property (p_comb_inv_r6);

   // R5: true registered mode shows the masked OR from the previous edge
   property p_reg_true_r5;
      @(posedge clk) disable iff (rst)
         ($past(!rst) && sel_mode == 2'b01) |-> (pin_out == $past(|(pterm & pterm_en)));
   endproperty
   a_reg_true_r5: assert property (p_reg_true_r5);

   // R8: pin and feedback differ only by the polarity bit
   property p_fb_polarity_r8;
      @(posedge clk) disable iff (rst)
         1'b1 |-> (pin_out == (sel_mode[0] ? fb_out : ~fb_out));
   endproperty
   a_fb_polarity_r8: assert property (p_fb_polarity_r8);

endmodule

// File: tb/olm_macrocell_tb.sv
module olm_macrocell_tb;
   localparam int unsigned NT = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    sel_mode = 2'b01;
   logic [NT-1:0] pterm = '0;
   logic [NT-1:0] pterm_en = '0;
   logic          pin_out;
   logic          fb_out;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;
   logic model_q = 1'b0;

   always #5 clk = ~clk;

   olm_macrocell #(.N_TERMS(NT)) u_dut (
      .clk      (clk),
      .rst      (rst),
      .sel_mode (sel_mode),
      .pterm    (pterm),
      .pterm_en (pterm_en),
      .pin_out  (pin_out),
      .fb_out   (fb_out)
   );

   function automatic logic want_sum(input logic [NT-1:0] t, input logic [NT-1:0] e);
      logic s = 1'b0;
      for (int i = 0; i < NT; i++) if (e[i]) s = s | t[i];
      return s;
   endfunction

   function automatic logic want_pin(input logic [1:0] m, input logic qv, input logic s);
      case (m)
         2'b00:   return !qv;
         2'b01:   return qv;
         2'b10:   return !s;
         default: return s;
      endcase
   endfunction

   function automatic logic want_fb(input logic [1:0] m, input logic qv, input logic s);
      return m[1] ? s : qv;
   endfunction

   function automatic string tag_of(input logic [1:0] m);
      case (m)
         2'b00:   return "R4";
         2'b01:   return "R5";
         2'b10:   return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b (mode %b t %h e %h)",
                  req, act, exp, sel_mode, pterm, pterm_en);
      end
   endtask

   task automatic check_outputs(input string extra);
      logic s = want_sum(pterm, pterm_en);
      check({tag_of(sel_mode), extra}, pin_out, want_pin(sel_mode, model_q, s));
      check({"R8", extra}, fb_out, want_fb(sel_mode, model_q, s));
   endtask

   // drive at the falling edge, check, then let the rising edge update the model
   task automatic cycle(input logic r, input logic [1:0] m,
                        input logic [NT-1:0] t, input logic [NT-1:0] e);
      @(negedge clk);
      rst = r; sel_mode = m; pterm = t; pterm_en = e;
      #1;
      if (!r) check_outputs("");
      @(posedge clk);
      model_q = r ? 1'b0 : want_sum(t, e);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0101));
      // R3: reset clears the flip-flop
      cycle(1'b1, 2'b01, 8'hFF, 8'hFF);
      cycle(1'b1, 2'b01, 8'hFF, 8'hFF);
      @(negedge clk); rst = 1'b0; sel_mode = 2'b01; pterm = '0; pterm_en = '0; #1;
      check("R3 high", pin_out, 1'b0);
      sel_mode = 2'b00; #1;
      check("R3 low", pin_out, 1'b1);

      // R1: all-zero mask gives zero sum
      cycle(1'b0, 2'b11, 8'hFF, 8'h00);
      check("R1 zero-mask", pin_out, 1'b0);
      // R10: masked-off terms ignored, seen through the register too
      cycle(1'b0, 2'b11, 8'hF0, 8'h0F);
      @(negedge clk); sel_mode = 2'b01; pterm = '0; pterm_en = '0; #1;
      check("R10 reg", pin_out, 1'b0);
      // R1: single enabled term at each end
      cycle(1'b0, 2'b11, 8'h01, 8'h01);
      cycle(1'b0, 2'b11, 8'h80, 8'h80);

      // R2: register loads 1, then shown in mode 01
      cycle(1'b0, 2'b10, 8'h10, 8'h10);
      @(negedge clk); sel_mode = 2'b01; pterm = '0; pterm_en = 8'hFF; #1;
      check("R2 load", pin_out, 1'b1);
      // R9: mode changes without clock: q=1, sum=0
      sel_mode = 2'b11; #1;
      check("R9 comb", pin_out, 1'b0);
      check("R9 fb", fb_out, 1'b0);
      sel_mode = 2'b00; #1;
      check("R9 reglow", pin_out, 1'b0);
      check("R9 fbreg", fb_out, 1'b1);
      sel_mode = 2'b10; #1;
      check("R9 comblow", pin_out, 1'b1);
      @(posedge clk); model_q = 1'b0;

      // random mix
      for (int i = 0; i < 2000; i++) begin
         logic r = (($urandom % 32) == 0);
         logic [1:0] m = 2'($urandom);
         logic [NT-1:0] t = NT'($urandom);
         logic [NT-1:0] e = NT'($urandom);
         if (($urandom % 4) == 0) e = '0;
         cycle(r, m, t, e);
      end
      finish_run();
   end

endmodule